// File: doc/BRIEF.md
# Converter Clock Period Generator

This block derives the per-bit period of a successive-approximation converter and times one complete conversion. In its divider mode the period spans a programmable number of system clock cycles, each cycle standing for one instruction cycle. In its alternate mode each period is one pulse of an enable that stands in for a slower internal oscillator. A start strobe opens a conversion. The block emits one period tick per bit period. After a fixed count of periods it drops busy and raises a one-cycle done pulse. The fixed count is 12 for the lower resolution and 14 for the higher one.

The configuration is captured when a start is accepted, so later changes to the inputs cannot disturb a conversion in progress. A start that arrives while a conversion is running is dropped, and it leaves a sticky overrun flag behind. A separate combinational flag warns when the selected divider gives a period shorter than the minimum period. That check uses a parameter for the system clock period.

Top module: `adc_tad_gen`

## Requirements
- R1: After reset, busy_o, done_o, tad_tick_o and overrun_o are all low.
- R2: With src_sel_i = 0 captured and divide value N, tad_tick_o is high in conversion cycles k(N+1)-1 and in no other cycle (k = 1, 2, ...). Cycle 0 is the first cycle after the clock edge that accepts the start, so the first tick is aligned to the start.
- R3: A conversion holds exactly T periods: T = 12 when hires_i = 0 and T = 14 when hires_i = 1 at start. busy_o is high for T(N+1) cycles in divider mode.
- R4: done_o is high for exactly one cycle, the cycle right after the last tick, and busy_o is already low in that cycle.
- R5: With src_sel_i = 1 captured, a tick is produced in each busy cycle in which alt_en_i is high. div_i has no effect on the conversion length.
- R6: div_i, src_sel_i and hires_i are captured when a start is accepted. Changing them while busy_o is high does not change the tick positions or the conversion length.
- R7: A start while busy_o is high is ignored and the conversion length does not change. It sets overrun_o, which stays high until reset.
- R8: A start given in the done cycle is accepted, and it begins a new full-length conversion with no idle cycle in between.
- R9: too_fast_o is high when src_sel_i = 0 and (div_i+1)·TCY_PS < MIN_TAD_PS. It is low otherwise. With the default parameters, div_i ≤ 8 is flagged and div_i ≥ 9 is not.
- R10: tad_tick_o stays low whenever busy_o is low, even when alt_en_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, one instruction cycle per period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Divide value N, period = N+1 cycles |
| src_sel_i | input | 1 | 1 selects the alternate clock enable as the period source |
| hires_i | input | 1 | Resolution mode: 0 gives 12 periods, 1 gives 14 periods |
| alt_en_i | input | 1 | Alternate clock, one pulse per period |
| start_i | input | 1 | Start-conversion strobe |
| tad_tick_o | output | 1 | One-cycle tick per conversion period |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle conversion-complete pulse |
| overrun_o | output | 1 | Sticky: a start arrived while busy |
| too_fast_o | output | 1 | The current divider setting gives a period below the minimum |

## Verification
Random divide values and both resolution modes exercise divider mode. For every cycle the bench predicts whether a tick is present, which separates off-by-one errors in the divider from errors in the period count. In alternate mode the enable pulses follow a random spacing while div_i is random, which shows whether the divider is truly bypassed. Directed cases cover the following:
- Divide values 0 and 255.
- Changing the configuration in mid-conversion.
- A start while busy.
- A start in the done cycle.
- The two divide values on either side of the minimum-period threshold.

// File: rtl/adc_tad_pkg.sv
package adc_tad_pkg;
  typedef enum logic {RES_LO = 1'b0, RES_HI = 1'b1} res_mode_e;

  function automatic int min_mult(input int tcy_ps, input int min_ps);
    return (min_ps + tcy_ps - 1) / tcy_ps;
  endfunction
endpackage

// File: rtl/tad_divider.sv
module tad_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             use_alt_i,
  input  logic             alt_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = 1;

  logic [DIV_W-1:0] cnt_q;

  always_comb begin
    if (!run_i)         tick_o = 1'b0;
    else if (use_alt_i) tick_o = alt_en_i;
    else                tick_o = (cnt_q == div_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (!run_i || restart_i || tick_o)    cnt_q <= '0;
    else if (!use_alt_i)                       cnt_q <= cnt_q + ONE;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !use_alt_i) |-> (cnt_q <= div_i));

  // R10
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int DIV_W   = 8,
  parameter int TADS_LO = 12,
  parameter int TADS_HI = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             src_sel_i,
  input  logic             hires_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [DIV_W-1:0] div_q_o,
  output logic             src_q_o
);
  import adc_tad_pkg::*;

  localparam int TCW = $clog2(TADS_HI + 1);
  localparam logic [TCW-1:0] ONE     = 1;
  localparam logic [TCW-1:0] LAST_LO = TCW'(TADS_LO - 1);
  localparam logic [TCW-1:0] LAST_HI = TCW'(TADS_HI - 1);

  logic [TCW-1:0] tad_cnt_q;
  logic [TCW-1:0] last_q;
  res_mode_e      mode;

  assign mode     = res_mode_e'(hires_i);
  assign accept_o = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      tad_cnt_q <= '0;
      last_q    <= LAST_LO;
      div_q_o   <= '0;
      src_q_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept_o) begin
        busy_o    <= 1'b1;
        tad_cnt_q <= '0;
        last_q    <= (mode == RES_HI) ? LAST_HI : LAST_LO;
        div_q_o   <= div_i;
        src_q_o   <= src_sel_i;
      end else if (busy_o && tick_i) begin
        if (tad_cnt_q == last_q) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          tad_cnt_q <= tad_cnt_q + ONE;
        end
      end
    end
  end

  // R4
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !accept_o |=> !done_o);

  // R3
  tad_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (tad_cnt_q <= last_q));

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || ($stable(div_q_o) && $stable(src_q_o) && $stable(last_q))));
endmodule

// File: rtl/tad_cfg_check.sv
module tad_cfg_check #(
  parameter int DIV_W      = 8,
  parameter int TCY_PS     = 8000,
  parameter int MIN_TAD_PS = 75000
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic             src_sel_i,
  output logic             too_fast_o
);
  import adc_tad_pkg::*;

  localparam int MULT = min_mult(TCY_PS, MIN_TAD_PS);

  generate
    if (MULT <= 1) begin : g_never
      assign too_fast_o = 1'b0;
    end else if (MULT > (1 << DIV_W)) begin : g_always
      assign too_fast_o = !src_sel_i;
    end else begin : g_cmp
      localparam logic [DIV_W:0] LIM = (DIV_W + 1)'(MULT - 1);
      assign too_fast_o = !src_sel_i && ({1'b0, div_i} < LIM);
    end
  endgenerate
endmodule

// File: rtl/adc_tad_gen.sv
module adc_tad_gen #(
  parameter int DIV_W      = 8,
  parameter int TADS_LO    = 12,
  parameter int TADS_HI    = 14,
  parameter int TCY_PS     = 8000,
  parameter int MIN_TAD_PS = 75000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             src_sel_i,
  input  logic             hires_i,
  input  logic             alt_en_i,
  input  logic             start_i,
  output logic             tad_tick_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             overrun_o,
  output logic             too_fast_o
);
  logic             accept;
  logic [DIV_W-1:0] div_q;
  logic             src_q;

  conv_sequencer #(
    .DIV_W(DIV_W), .TADS_LO(TADS_LO), .TADS_HI(TADS_HI)
  ) i_seq (
    .clk_i, .rst_ni, .start_i,
    .tick_i    (tad_tick_o),
    .div_i, .src_sel_i, .hires_i,
    .accept_o  (accept),
    .busy_o, .done_o,
    .div_q_o   (div_q),
    .src_q_o   (src_q)
  );

  tad_divider #(.DIV_W(DIV_W)) i_div (
    .clk_i, .rst_ni,
    .run_i     (busy_o),
    .restart_i (accept),
    .use_alt_i (src_q),
    .alt_en_i,
    .div_i     (div_q),
    .tick_o    (tad_tick_o)
  );

  tad_cfg_check #(
    .DIV_W(DIV_W), .TCY_PS(TCY_PS), .MIN_TAD_PS(MIN_TAD_PS)
  ) i_cfg (
    .div_i, .src_sel_i, .too_fast_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  overrun_o <= 1'b0;
    else if (start_i && busy_o)   overrun_o <= 1'b1;
  end

  // R7
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  // R7
  overrun_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(busy_o));

  // R10
  tick_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tad_tick_o);
endmodule

// File: tb/test_adc_tad_gen.sv
module test_adc_tad_gen;
  localparam int CLK_NS = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_i = '0;
  logic       src_sel_i = 1'b0;
  logic       hires_i = 1'b0;
  logic       alt_en_i = 1'b0;
  logic       start_i = 1'b0;
  logic       tad_tick_o, busy_o, done_o, overrun_o, too_fast_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  adc_tad_gen i_adc_tad_gen (
    .clk_i, .rst_ni, .div_i, .src_sel_i, .hires_i, .alt_en_i, .start_i,
    .tad_tick_o, .busy_o, .done_o, .overrun_o, .too_fast_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_tads(input bit hr);
    return hr ? 14 : 12;
  endfunction

  function automatic bit exp_too_fast(input int n, input bit src);
    return !src && ((n + 1) * 8000 < 75000);
  endfunction

  // Caller is in the low clock phase. Drives a start now, then follows the conversion.
  task automatic run_conv(input int n, input bit src, input bit hr, input int p,
                          input int chg_at, input int ovr_at, input string tag);
    int len, busy_cnt, ticks, bad, done_j;
    bit exp_tick, alt;
    len = src ? exp_tads(hr) * p : exp_tads(hr) * (n + 1);
    busy_cnt = 0; ticks = 0; bad = 0; done_j = -1;
    div_i = 8'(n); src_sel_i = src; hires_i = hr; alt_en_i = 1'b0; start_i = 1'b1;
    for (int j = 0; j < 5000; j++) begin
      @(negedge clk_i);
      start_i  = (j == ovr_at);
      alt      = src && ((j + 1) % p == 0);
      alt_en_i = alt;
      if (j == chg_at) begin
        div_i = 8'($urandom);
        hires_i = ~hr;
        src_sel_i = ~src;
      end
      #1;
      if (busy_o) busy_cnt++;
      if (tad_tick_o) ticks++;
      exp_tick = (j < len) && (src ? alt : ((j + 1) % (n + 1) == 0));
      if (tad_tick_o != exp_tick) bad++;
      if (done_o) begin
        done_j = j;
        break;
      end
    end
    start_i = 1'b0; alt_en_i = 1'b0;
    chk(bad == 0, {tag, " R2/R5 tick positions"}, bad, 0);
    chk(ticks == exp_tads(hr), {tag, " R3 tick count"}, ticks, exp_tads(hr));
    chk(busy_cnt == len, {tag, " R3 busy length"}, busy_cnt, len);
    chk(done_j == len && !busy_o, {tag, " R4 done cycle"}, done_j, len);
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) @(negedge clk_i);
    #1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    #(CLK_NS * 3 + 1);
    chk(!busy_o && !done_o && !tad_tick_o && !overrun_o, "R1 reset state",
        {busy_o, done_o, tad_tick_o, overrun_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);

    // R2 R3 directed extremes
    run_conv(0, 0, 0, 1, -1, -1, "r2_div0_lo");
    idle(1);
    run_conv(0, 0, 1, 1, -1, -1, "r3_div0_hi");
    idle(1);
    run_conv(255, 0, 1, 1, -1, -1, "r2_div255");
    idle(1);

    // R5 alternate source, div ignored
    run_conv(200, 1, 0, 3, -1, -1, "r5_alt");
    idle(1);
    run_conv(0, 1, 1, 1, -1, -1, "r5_alt_every");
    idle(1);

    // R6 config changes mid-conversion
    run_conv(5, 0, 0, 1, 7, -1, "r6_chg_div");
    idle(1);
    run_conv(9, 1, 1, 4, 3, -1, "r6_chg_alt");
    idle(1);

    // R8 back-to-back start in the done cycle
    run_conv(2, 0, 0, 1, -1, -1, "r8_first");
    run_conv(3, 0, 1, 1, -1, -1, "r8_second");
    idle(1);

    // random mix (R2 R3 R5)
    for (int i = 0; i < 30; i++) begin
      int n, p;
      bit s, h;
      n = int'($urandom_range(0, 40));
      s = 1'($urandom_range(0, 3) == 0);
      h = 1'($urandom);
      p = int'($urandom_range(1, 6));
      run_conv(n, s, h, p, -1, -1, "rand");
      idle(int'($urandom_range(1, 3)));
    end
    chk(!overrun_o, "R7 no overrun without busy start", overrun_o, 0);

    // R10 idle with alternate enable high
    src_sel_i = 1'b1; alt_en_i = 1'b1;
    idle(3);
    chk(!tad_tick_o && !busy_o, "R10 no tick while idle", tad_tick_o, 0);
    alt_en_i = 1'b0;

    // R9 threshold
    src_sel_i = 1'b0; div_i = 8'd8; #1;
    chk(too_fast_o == exp_too_fast(8, 0), "R9 div 8", too_fast_o, exp_too_fast(8, 0));
    div_i = 8'd9; #1;
    chk(too_fast_o == exp_too_fast(9, 0), "R9 div 9", too_fast_o, exp_too_fast(9, 0));
    div_i = 8'd0; src_sel_i = 1'b1; #1;
    chk(too_fast_o == exp_too_fast(0, 1), "R9 alt source", too_fast_o, exp_too_fast(0, 1));
    for (int i = 0; i < 10; i++) begin
      int n;
      n = int'($urandom_range(0, 255));
      div_i = 8'(n); src_sel_i = 1'b0; #1;
      chk(too_fast_o == exp_too_fast(n, 0), "R9 random div", too_fast_o, exp_too_fast(n, 0));
    end
    idle(1);

    // R7 start while busy
    run_conv(4, 0, 0, 1, -1, 6, "r7_overrun");
    idle(2);
    chk(overrun_o, "R7 overrun sticky", overrun_o, 1);
    run_conv(1, 0, 0, 1, -1, -1, "r7_after");
    chk(overrun_o, "R7 overrun still set", overrun_o, 1);

    // R1 reset clears sticky flag
    rst_ni = 1'b0; #2;
    chk(!overrun_o && !busy_o, "R1 reset clears overrun", overrun_o, 0);
    idle(1);
    rst_ni = 1'b1;
    idle(2);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule